// File: doc/BRIEF.md
# Four-Class Egress Transmission Scheduler

This block chooses which of four egress queues of a single network port puts the next frame on the wire. The queues are a time-scheduled class, two bandwidth-reserved stream classes (called A and B), and a best-effort class. Each queue presents a head-of-line valid flag and the byte length of the frame at its head. When the port is idle, the scheduler grants one queue. It then holds that grant, with a busy flag raised and the granted frame length latched, until the transmitter signals end of frame.

The two reserved classes are each guarded by a credit shaper. A class waiting to send gains credit at its idle slope. It loses credit at its send slope for every clock it is on the wire. It may only begin a frame while its credit is zero or above. The scheduled class sits above both shaped classes, carries no credit, and is never held back. The best-effort class is served last, by plain strict priority. The slopes are signed per-clock byte amounts written through a small configuration port.

Top module: `egress_class_sched`

## Requirements
- R1: `grant` is one-hot or zero, with bit 0 for scheduled, bit 1 for class A, bit 2 for class B and bit 3 for best effort. `busy` is high exactly while `grant` is non-zero. A grant is held unchanged, whatever the queues do, until `tx_eof` is seen while busy. `grant` and `busy` then clear on the next clock edge, and a new selection may be made on the edge after that.
- R2: A valid scheduled queue wins every selection, and it is never delayed by credit. A scheduled queue that is still valid at end of frame is granted again at the next selection.
- R3: Among eligible queues the order is scheduled, then class A, then class B, then best effort.
- R4: A shaped class is eligible only while its signed credit is zero or above. Its credit changes by the send slope on each clock it is granted and busy. It changes by the idle slope on each clock its queue is valid and it is not transmitting. A class that has gone negative recovers by waiting.
- R5: On a clock when a shaped queue is empty and not transmitting, a positive credit is set to zero. A negative credit rises by the idle slope, but never above zero.
- R6: The best-effort queue is granted only when no scheduled frame is valid and neither shaped class is eligible.
- R7: `tx_len` takes the length field of the granted queue on the grant edge and stays stable for the whole frame. Queue i's length is at `q_len[i*LEN_W +: LEN_W]`.
- R8: When `cfg_we` is high on a clock edge, the idle and send slopes of the class chosen by `cfg_cls` (0 = A, 1 = B) are loaded. The slopes are signed two's complement bytes per clock, and they act from the next clock. For example, a send slope of zero lets a class send back to back.
- R9: On synchronous reset `grant`, `busy` and `tx_len` are zero, both credits are zero, and the slopes return to their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 4 | Head-of-line frame present, one bit per queue |
| q_len | input | 4*LEN_W | Head-of-line frame length per queue, in bytes |
| tx_eof | input | 1 | Transmitter reports end of the current frame |
| cfg_we | input | 1 | Load slopes for the selected shaped class |
| cfg_cls | input | 1 | Class chosen for loading: 0 = A, 1 = B |
| cfg_idle_slope | input | SLOPE_W | Signed credit gain per waiting clock |
| cfg_send_slope | input | SLOPE_W | Signed credit change per transmitting clock |
| grant | output | 4 | One-hot grant of the queue now transmitting |
| busy | output | 1 | A frame is on the wire |
| tx_len | output | LEN_W | Length of the granted frame |

## Verification
A grant appears on the first rising edge that finds the port idle with some queue eligible. `busy` and `grant` drop one edge after `tx_eof` is seen, and the next grant is due one edge later still, so each hand-over costs two edges. The bench changes inputs on falling edges and samples on the falling edge that follows the edge on which a result is due: one falling edge after a fresh request, and two after raising `tx_eof`. Frame lengths in clocks are chosen with wide margins over the credit crossings they aim at, so each expected grant depends only on the sign of a credit and not on an exact count.

// File: rtl/egs_pkg.sv
package egs_pkg;

    localparam int NQ = 4;

    typedef enum logic [1:0] {
        Q_SCHED = 2'd0,
        Q_CLS_A = 2'd1,
        Q_CLS_B = 2'd2,
        Q_BEST  = 2'd3
    } queue_e;

    // lowest-index set bit wins: index order is the priority order
    function automatic logic [NQ-1:0] pick_first(input logic [NQ-1:0] req);
        logic [NQ-1:0] res;
        res = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[i]) res = '0;
            if (req[i]) res[i] = 1'b1;
        end
        return res;
    endfunction

endpackage

// File: rtl/egs_credit_shaper.sv
module egs_credit_shaper #(
    parameter int SLOPE_W = 12,
    parameter int CRED_W  = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      q_valid,
    input  logic                      sending,
    input  logic signed [SLOPE_W-1:0] idle_slope,
    input  logic signed [SLOPE_W-1:0] send_slope,
    output logic signed [CRED_W-1:0]  credit,
    output logic                      eligible
);
    localparam int EXT_W = CRED_W + 1;
    localparam logic signed [EXT_W-1:0] CMAX = {2'b00, {(CRED_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] CMIN = {2'b11, {(CRED_W-1){1'b0}}};

    logic signed [SLOPE_W-1:0] step;
    logic signed [EXT_W-1:0]   sum;
    logic signed [CRED_W-1:0]  sat;
    logic signed [CRED_W-1:0]  nxt;

    always_comb begin
        if (sending)
            step = send_slope;
        else
            step = idle_slope;
        sum = $signed({credit[CRED_W-1], credit})
            + $signed({{(EXT_W-SLOPE_W){step[SLOPE_W-1]}}, step});
        if (sum > CMAX)
            sat = CMAX[CRED_W-1:0];
        else if (sum < CMIN)
            sat = CMIN[CRED_W-1:0];
        else
            sat = sum[CRED_W-1:0];

        if (sending || q_valid)
            nxt = sat;
        else if (credit > 0)
            nxt = '0;
        else if (sat > 0)
            nxt = '0;
        else
            nxt = sat;
    end

    always_ff @(posedge clk) begin
        if (rst)
            credit <= '0;
        else
            credit <= nxt;
    end

    assign eligible = q_valid && !credit[CRED_W-1];

endmodule

// File: rtl/egs_grant_ctrl.sv
module egs_grant_ctrl
    import egs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NQ-1:0]         eligible,
    input  logic [NQ*LEN_W-1:0]   q_len,
    input  logic                  tx_eof,
    output logic [NQ-1:0]         grant,
    output logic                  busy,
    output logic [LEN_W-1:0]      tx_len
);
    logic [NQ-1:0]    winner;
    logic [LEN_W-1:0] win_len;

    always_comb begin
        winner  = pick_first(eligible);
        win_len = '0;
        for (int i = 0; i < NQ; i++)
            if (winner[i]) win_len = q_len[i*LEN_W +: LEN_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant  <= '0;
            busy   <= 1'b0;
            tx_len <= '0;
        end else if (busy) begin
            if (tx_eof) begin
                grant <= '0;
                busy  <= 1'b0;
            end
        end else if (|eligible) begin
            grant  <= winner;
            busy   <= 1'b1;
            tx_len <= win_len;
        end
    end

endmodule

// File: rtl/egs_slope_regs.sv
module egs_slope_regs #(
    parameter int SLOPE_W = 12,
    parameter int NCLS    = 2,
    parameter int DEF_IDLE = 4,
    parameter int DEF_SEND = -12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [$clog2(NCLS)-1:0]   cfg_cls,
    input  logic signed [SLOPE_W-1:0] cfg_idle_slope,
    input  logic signed [SLOPE_W-1:0] cfg_send_slope,
    output logic signed [SLOPE_W-1:0] idle_slope [NCLS],
    output logic signed [SLOPE_W-1:0] send_slope [NCLS]
);
    localparam logic signed [SLOPE_W-1:0] RST_IDLE = SLOPE_W'(DEF_IDLE);
    localparam logic signed [SLOPE_W-1:0] RST_SEND = SLOPE_W'(DEF_SEND);

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        always_ff @(posedge clk) begin
            if (rst) begin
                idle_slope[c] <= RST_IDLE;
                send_slope[c] <= RST_SEND;
            end else if (cfg_we && cfg_cls == c) begin
                idle_slope[c] <= cfg_idle_slope;
                send_slope[c] <= cfg_send_slope;
            end
        end
    end

endmodule

// File: rtl/egress_class_sched.sv
module egress_class_sched
    import egs_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int SLOPE_W  = 12,
    parameter int CRED_W   = 20,
    parameter int DEF_IDLE = 4,
    parameter int DEF_SEND = -12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [3:0]                q_valid,
    input  logic [4*LEN_W-1:0]        q_len,
    input  logic                      tx_eof,
    input  logic                      cfg_we,
    input  logic                      cfg_cls,
    input  logic signed [SLOPE_W-1:0] cfg_idle_slope,
    input  logic signed [SLOPE_W-1:0] cfg_send_slope,
    output logic [3:0]                grant,
    output logic                      busy,
    output logic [LEN_W-1:0]          tx_len
);
    localparam int NCLS = 2;

    logic signed [SLOPE_W-1:0] idle_slope [NCLS];
    logic signed [SLOPE_W-1:0] send_slope [NCLS];
    logic signed [CRED_W-1:0]  cred       [NCLS];
    logic [NCLS-1:0]           shaped_ok;
    logic [NQ-1:0]             eligible;
    logic signed [CRED_W-1:0]  credit_a;
    logic signed [CRED_W-1:0]  credit_b;

    egs_slope_regs #(
        .SLOPE_W (SLOPE_W),
        .NCLS    (NCLS),
        .DEF_IDLE(DEF_IDLE),
        .DEF_SEND(DEF_SEND)
    ) u_slopes (
        .clk           (clk),
        .rst           (rst),
        .cfg_we        (cfg_we),
        .cfg_cls       (cfg_cls),
        .cfg_idle_slope(cfg_idle_slope),
        .cfg_send_slope(cfg_send_slope),
        .idle_slope    (idle_slope),
        .send_slope    (send_slope)
    );

    // shaped classes occupy queue indices Q_CLS_A and Q_CLS_B
    for (genvar c = 0; c < NCLS; c++) begin : g_shaper
        localparam int QI = int'(Q_CLS_A) + c;
        egs_credit_shaper #(
            .SLOPE_W(SLOPE_W),
            .CRED_W (CRED_W)
        ) u_shaper (
            .clk       (clk),
            .rst       (rst),
            .q_valid   (q_valid[QI]),
            .sending   (busy && grant[QI]),
            .idle_slope(idle_slope[c]),
            .send_slope(send_slope[c]),
            .credit    (cred[c]),
            .eligible  (shaped_ok[c])
        );
    end

    assign eligible[Q_SCHED] = q_valid[Q_SCHED];
    assign eligible[Q_CLS_A] = shaped_ok[0];
    assign eligible[Q_CLS_B] = shaped_ok[1];
    assign eligible[Q_BEST]  = q_valid[Q_BEST];
    assign credit_a = cred[0];
    assign credit_b = cred[1];

    egs_grant_ctrl #(
        .LEN_W(LEN_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .eligible(eligible),
        .q_len   (q_len),
        .tx_eof  (tx_eof),
        .grant   (grant),
        .busy    (busy),
        .tx_len  (tx_len)
    );

endmodule

// File: rtl/egs_sched_chk.sv
module egs_sched_chk #(
    parameter int CRED_W = 20
) (
    input logic                     clk,
    input logic                     rst,
    input logic [3:0]               q_valid,
    input logic                     tx_eof,
    input logic [3:0]               grant,
    input logic                     busy,
    input logic signed [CRED_W-1:0] credit_a,
    input logic signed [CRED_W-1:0] credit_b
);
    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R1
    busy_grant_chk: assert property (@(posedge clk) disable iff (rst)
        busy == (grant != 4'b0000));

    // R1
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !tx_eof |=> busy && $stable(grant));

    // R1
    eof_release_chk: assert property (@(posedge clk) disable iff (rst)
        busy && tx_eof |=> !busy);

    // R2
    sched_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> grant[0] == $past(q_valid[0]));

    // R4
    credit_gate_a_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && grant[1] |-> !$past(credit_a[CRED_W-1]));

    // R4
    credit_gate_b_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && grant[2] |-> !$past(credit_b[CRED_W-1]));

    // R5
    empty_zero_a_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && !q_valid[1] && credit_a > 0 |=> credit_a == 0);

    // R6
    best_last_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) && grant[3] |-> !$past(q_valid[0]));

endmodule

bind egress_class_sched egs_sched_chk #(.CRED_W(CRED_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .q_valid (q_valid),
    .tx_eof  (tx_eof),
    .grant   (grant),
    .busy    (busy),
    .credit_a(credit_a),
    .credit_b(credit_b)
);

// File: tb/egress_class_sched_tb.sv
`timescale 1ns/1ps
module egress_class_sched_tb;
    localparam int LEN_W   = 16;
    localparam int SLOPE_W = 12;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [3:0]                q_valid = '0;
    logic [4*LEN_W-1:0]        q_len = '0;
    logic                      tx_eof = 1'b0;
    logic                      cfg_we = 1'b0;
    logic                      cfg_cls = 1'b0;
    logic signed [SLOPE_W-1:0] cfg_idle_slope = '0;
    logic signed [SLOPE_W-1:0] cfg_send_slope = '0;
    logic [3:0]                grant;
    logic                      busy;
    logic [LEN_W-1:0]          tx_len;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    egress_class_sched #(.LEN_W(LEN_W), .SLOPE_W(SLOPE_W)) u_dut (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_len(q_len),
        .tx_eof(tx_eof), .cfg_we(cfg_we), .cfg_cls(cfg_cls),
        .cfg_idle_slope(cfg_idle_slope), .cfg_send_slope(cfg_send_slope),
        .grant(grant), .busy(busy), .tx_len(tx_len)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // end the current frame; returns at the falling edge after the clearing edge
    task automatic end_frame();
        tx_eof = 1'b1;
        step(1);
        tx_eof = 1'b0;
    endtask

    task automatic write_slopes(input logic cls, input int idle, input int send);
        cfg_we = 1'b1;
        cfg_cls = cls;
        cfg_idle_slope = SLOPE_W'(idle);
        cfg_send_slope = SLOPE_W'(send);
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic drain();
        q_valid = '0;
        if (busy) end_frame();
        step(150);
    endtask

    task automatic t_reset();
        check("R9 grant after reset", {28'd0, grant}, 32'd0);
        check("R9 busy after reset", {31'd0, busy}, 32'd0);
        check("R9 tx_len after reset", {16'd0, tx_len}, 32'd0);
    endtask

    task automatic t_arbitration();
        q_len = {16'd400, 16'd300, 16'd200, 16'd100};
        q_valid = 4'b1111;
        step(1);
        check("R2 scheduled wins", {28'd0, grant}, 32'h1);
        check("R1 busy with grant", {31'd0, busy}, 32'd1);
        check("R7 latched length", {16'd0, tx_len}, 32'd100);
        q_len = {16'd7, 16'd7, 16'd7, 16'd7};
        q_valid[0] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R1 grant held", {28'd0, grant}, 32'h1);
            check("R7 length stable", {16'd0, tx_len}, 32'd100);
        end
        end_frame();
        check("R1 grant cleared after eof", {28'd0, grant}, 32'h0);
        check("R1 busy cleared after eof", {31'd0, busy}, 32'd0);
        step(1);
        check("R3 class A over B", {28'd0, grant}, 32'h2);
        step(20);
        end_frame();
        step(1);
        check("R4 A blocked by negative credit, B sent", {28'd0, grant}, 32'h4);
        step(30);
        end_frame();
        step(1);
        check("R6 best effort when shaped blocked", {28'd0, grant}, 32'h8);
        step(50);
        end_frame();
        step(1);
        check("R4 A recovered by idle slope", {28'd0, grant}, 32'h2);
        drain();
        check("R1 idle with no queues", {27'd0, busy, grant}, 32'd0);
    endtask

    task automatic t_sched_bypass();
        q_valid = 4'b0011;
        step(1);
        check("R2 scheduled first", {28'd0, grant}, 32'h1);
        step(40);
        end_frame();
        step(1);
        check("R2 scheduled regranted without shaping", {28'd0, grant}, 32'h1);
        q_valid[0] = 1'b0;
        end_frame();
        step(1);
        check("R3 A after scheduled", {28'd0, grant}, 32'h2);
        drain();
    endtask

    task automatic t_empty_zero();
        q_valid = 4'b0101;
        step(1);
        check("R2 scheduled over B", {28'd0, grant}, 32'h1);
        step(100);
        q_valid[2] = 1'b0;
        step(2);
        q_valid[2] = 1'b1;
        step(2);
        q_valid = 4'b1100;
        end_frame();
        step(1);
        check("R5 B granted with small credit", {28'd0, grant}, 32'h4);
        step(5);
        end_frame();
        step(1);
        check("R5 banked credit cleared, B blocked", {28'd0, grant}, 32'h8);
        drain();
    endtask

    task automatic t_cfg();
        write_slopes(1'b1, 4, 0);
        q_valid = 4'b1100;
        step(1);
        check("R8 B granted", {28'd0, grant}, 32'h4);
        step(20);
        end_frame();
        step(1);
        check("R8 zero send slope keeps B eligible", {28'd0, grant}, 32'h4);
        drain();
        write_slopes(1'b1, 4, -12);
        write_slopes(1'b0, 4, -12);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        t_reset();
        write_slopes(1'b0, 4, -12);
        write_slopes(1'b1, 4, -12);
        t_arbitration();
        t_sched_bypass();
        t_empty_zero();
        t_cfg();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule